// File: doc/BRIEF.md
# Oversampling Block Averager with Dither Timing

This block raises the effective resolution of a slow 10-bit converter by summing a fixed run of 64 accepted samples into a 16-bit total. It keeps the top 13 bits of each total, which is a divide by eight, and emits that word on a one-clock strobe. Only half of the six bits of growth are dropped. The three extra bits are meaningful only when the input carries a few codes of noise or dither.

A second output pair keeps an external triangular dither generator locked to the sample count. A one-clock sync pulse marks the first sample of every block. A square reference changes level at the half-block and at the block end. Every block therefore sees the same dither phase at the same sample index, and the dither averages out over one block. The dither should span about plus or minus two converter codes.

Top module: `osd_decimator`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block counter and the sum are cleared, and `word_valid`, `word_data`, `dith_sync` and `dith_ref` are all 0 after that edge.
- R2: A cycle with `smp_valid` low has no effect on the sum, the sample count or any output, whatever value `smp_code` holds.
- R3: `word_data` equals floor(S / 8), where S is the unsigned sum of the 64 accepted codes of the block. The result is 13 bits wide, with a largest value of 8184.
- R4: `word_valid` is high for exactly one clock, in the cycle right after the edge that accepts the 64th sample of a block.
- R5: The first sample accepted after the 64th sample starts a new sum, with no gap cycle. The same sample is never counted in two blocks.
- R6: `dith_sync` is a one-clock pulse in the cycle after the edge that accepts the first sample (index 0) of each block.
- R7: `dith_ref` is 0 once sample index 63 has been accepted and after reset. It becomes 1 after the edge that accepts sample index 31, and it changes at no other time.
- R8: A reset in the middle of a block discards the partial sum. The next word covers only the 64 samples accepted after reset.
- R9: `word_data` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_code | input | 10 | Unsigned converter code |
| word_valid | output | 1 | One-clock strobe for a finished block |
| word_data | output | 13 | Block sum divided by eight |
| dith_sync | output | 1 | Phase restart pulse for the dither source |
| dith_ref | output | 1 | Square reference, one period per block |

## Verification
The bench runs blocks at full rate, back to back, which would expose a design that loses or repeats a sample at the boundary: its words would come out too small or too large. It drives all-maximum codes to catch a sum that is too narrow and wraps below 8184. It also drives sums whose low three bits are 7, to catch rounding where the spec asks for truncation. Idle cycles carry random codes, so a design that adds samples without the strobe drifts upward. A reset partway through a block would leave stale partial sums in a design that fails to clear them. A strobe one cycle late shows up as an off-by-one in `word_valid`, `dith_sync` or `dith_ref`.

// File: rtl/osd_pkg.sv
// Shared constants for the oversampling averager.
// Assumes the block length is a power of two.
package osd_pkg;
    parameter int OSD_SMP_W  = 10;  // converter code width
    parameter int OSD_LOG2_N = 6;   // log2 of samples per block
    parameter int OSD_DROP   = 3;   // low bits discarded from the sum

    // Width of the output word for given parameters.
    function automatic int osd_out_w(input int smp_w, input int log2_n, input int drop);
        return smp_w + log2_n - drop;
    endfunction
endpackage

// File: rtl/osd_block_ctr.sv
// Counts accepted samples modulo the block length.
// Assumes: synchronous active-low reset; counter advances only on smp_valid.
module osd_block_ctr #(
    parameter int LOG2_N = osd_pkg::OSD_LOG2_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    output logic [LOG2_N-1:0] cnt,
    output logic              first,
    output logic              last
);
    localparam logic [LOG2_N-1:0] LAST_IDX = '1;

    // Advance sample index on each accepted sample, wrapping at block end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (smp_valid)
            cnt <= cnt + 1'b1;
    end

    // Decode block boundary positions of the current index.
    always_comb begin
        first = (cnt == '0);
        last  = (cnt == LAST_IDX);
    end
endmodule

// File: rtl/osd_accum.sv
// Block accumulator: restarts on index 0, publishes truncated sum at index last.
// Assumes first/last describe the index of the sample presented this cycle.
module osd_accum #(
    parameter int SMP_W  = osd_pkg::OSD_SMP_W,
    parameter int LOG2_N = osd_pkg::OSD_LOG2_N,
    parameter int DROP   = osd_pkg::OSD_DROP
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          smp_valid,
    input  logic [SMP_W-1:0]                              smp_code,
    input  logic                                          first,
    input  logic                                          last,
    output logic                                          word_valid,
    output logic [osd_pkg::osd_out_w(SMP_W,LOG2_N,DROP)-1:0] word_data
);
    localparam int SUM_W = SMP_W + LOG2_N;
    localparam int OUT_W = osd_pkg::osd_out_w(SMP_W, LOG2_N, DROP);

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] sum_next;

    // Running sum including this sample; restart from zero on the first index.
    always_comb begin
        sum_next = (first ? '0 : acc) + SUM_W'(smp_code);
    end

    // Hold the running sum across accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (smp_valid)
            acc <= sum_next;
    end

    // Publish the truncated block sum with a one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= smp_valid && last;
            if (smp_valid && last)
                word_data <= OUT_W'(sum_next >> DROP);
        end
    end
endmodule

// File: rtl/osd_dither_tmg.sv
// Dither timing: sync pulse after index 0, square reference flipping each half block.
// Assumes cnt is the index of the sample presented this cycle.
module osd_dither_tmg #(
    parameter int LOG2_N = osd_pkg::OSD_LOG2_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [LOG2_N-1:0] cnt,
    input  logic              first,
    input  logic              last,
    output logic              dith_sync,
    output logic              dith_ref
);
    localparam int HALF = 1 << (LOG2_N - 1);
    localparam logic [LOG2_N-1:0] MID_IDX = LOG2_N'(HALF - 1);

    // Pulse the phase restart once per block, on the index 0 sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dith_sync <= 1'b0;
        else
            dith_sync <= smp_valid && first;
    end

    // Square reference: rise after the mid index, fall after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dith_ref <= 1'b0;
        else if (smp_valid && cnt == MID_IDX)
            dith_ref <= 1'b1;
        else if (smp_valid && last)
            dith_ref <= 1'b0;
    end
endmodule

// File: rtl/osd_decimator.sv
// Top: oversample-and-decimate resolution extender with dither timing.
// Assumes one converter code per smp_valid cycle; synchronous active-low reset.
module osd_decimator #(
    parameter int SMP_W  = osd_pkg::OSD_SMP_W,
    parameter int LOG2_N = osd_pkg::OSD_LOG2_N,
    parameter int DROP   = osd_pkg::OSD_DROP
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          smp_valid,
    input  logic [SMP_W-1:0]                              smp_code,
    output logic                                          word_valid,
    output logic [osd_pkg::osd_out_w(SMP_W,LOG2_N,DROP)-1:0] word_data,
    output logic                                          dith_sync,
    output logic                                          dith_ref
);
    logic [LOG2_N-1:0] cnt;
    logic              first;
    logic              last;

    osd_block_ctr #(.LOG2_N(LOG2_N)) u_ctr (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .cnt(cnt), .first(first), .last(last)
    );

    osd_accum #(.SMP_W(SMP_W), .LOG2_N(LOG2_N), .DROP(DROP)) u_acc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .first(first), .last(last),
        .word_valid(word_valid), .word_data(word_data)
    );

    osd_dither_tmg #(.LOG2_N(LOG2_N)) u_dth (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .cnt(cnt), .first(first), .last(last),
        .dith_sync(dith_sync), .dith_ref(dith_ref)
    );
endmodule

// File: rtl/osd_decimator_chk.sv
// Checker for osd_decimator, attached by bind; observes ports only.
module osd_decimator_chk #(
    parameter int SMP_W  = osd_pkg::OSD_SMP_W,
    parameter int LOG2_N = osd_pkg::OSD_LOG2_N,
    parameter int DROP   = osd_pkg::OSD_DROP
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          smp_valid,
    input logic [SMP_W-1:0]                              smp_code,
    input logic                                          word_valid,
    input logic [osd_pkg::osd_out_w(SMP_W,LOG2_N,DROP)-1:0] word_data,
    input logic                                          dith_sync,
    input logic                                          dith_ref
);
    localparam int OUT_W   = osd_pkg::osd_out_w(SMP_W, LOG2_N, DROP);
    localparam int MAX_OUT = (((1 << SMP_W) - 1) << LOG2_N) >> DROP;

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> !word_valid && !dith_sync && !dith_ref);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> $past(smp_valid));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> (word_data <= OUT_W'(MAX_OUT)));
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid);
    p_sync_src_r6: assert property (@(posedge clk) disable iff (!rst_n) dith_sync |-> $past(smp_valid));
    p_sync_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) dith_sync |=> !dith_sync);
    p_ref_low_r7: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> !dith_ref);
    p_ref_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) !$past(smp_valid) |-> $stable(dith_ref));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) !word_valid |-> $stable(word_data));
endmodule

bind osd_decimator osd_decimator_chk #(.SMP_W(SMP_W), .LOG2_N(LOG2_N), .DROP(DROP)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .word_valid(word_valid), .word_data(word_data),
    .dith_sync(dith_sync), .dith_ref(dith_ref)
);

// File: tb/sim_osd_decimator.sv
module sim_osd_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_code = '0;
    logic        word_valid;
    logic [12:0] word_data;
    logic        dith_sync;
    logic        dith_ref;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0;
    int m_sum = 0;
    int m_word = 0;
    int m_ref = 0;

    osd_decimator u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .word_valid(word_valid), .word_data(word_data),
        .dith_sync(dith_sync), .dith_ref(dith_ref)
    );

    always #4 clk = ~clk;

    function automatic int trunc_word(input int s);
        return s / 8;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after posedge, compare with model.
    task automatic step(input bit v, input int code);
        int ev;
        int es;
        @(negedge clk);
        smp_valid = v;
        smp_code  = 10'(code);
        @(posedge clk);
        #1;
        ev = 0; es = 0;
        if (v) begin
            if (m_cnt == 0) begin m_sum = 0; es = 1; end
            m_sum += code;
            if (m_cnt == 31) m_ref = 1;
            if (m_cnt == 63) begin ev = 1; m_word = trunc_word(m_sum); m_ref = 0; end
            m_cnt = (m_cnt + 1) % 64;
        end
        chk("R4 word_valid", int'(word_valid), ev);
        chk("R3/R9 word_data", int'(word_data), m_word);
        chk("R6 dith_sync", int'(dith_sync), es);
        chk("R7 dith_ref", int'(dith_ref), m_ref);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_cnt = 0; m_sum = 0; m_word = 0; m_ref = 0;
        chk("R1 reset word_valid", int'(word_valid), 0);
        chk("R1 reset word_data", int'(word_data), 0);
        chk("R1 reset dith_sync", int'(dith_sync), 0);
        chk("R1 reset dith_ref", int'(dith_ref), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R2: idle cycles with random codes must not disturb anything.
        for (int i = 0; i < 5; i++) step(0, $urandom_range(1023));
        // R3: all-maximum codes, largest word 8184.
        for (int i = 0; i < 64; i++) step(1, 1023);
        chk("R3 max word", int'(word_data), 8184);
        // R5: back-to-back all-zero block immediately after.
        for (int i = 0; i < 64; i++) step(1, 0);
        chk("R5 fresh block", int'(word_data), 0);
        // R3 truncation: sum = 63*0 + 7 -> word 0; then sum 64*1+7=71 -> 8.
        for (int i = 0; i < 64; i++) step(1, (i == 10) ? 7 : 0);
        chk("R3 truncation", int'(word_data), 0);
        for (int i = 0; i < 64; i++) step(1, (i == 0) ? 8 : 1);
        chk("R3 truncation", int'(word_data), 8);
        // R2/R7: random gaps and random codes over several blocks.
        for (int i = 0; i < 1200; i++) step(($urandom_range(99) < 60), $urandom_range(1023));
        // R8: reset in the middle of a block discards the partial sum.
        for (int i = 0; i < 30; i++) step(1, 1000);
        do_reset();
        for (int i = 0; i < 64; i++) step(1, 16);
        chk("R8 post-reset block", int'(word_data), 128);
        // R9: hold across idle cycles.
        for (int i = 0; i < 10; i++) step(0, $urandom_range(1023));
        chk("R9 hold", int'(word_data), 128);
        // R5: full-rate random blocks.
        for (int i = 0; i < 640; i++) step(1, $urandom_range(1023));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule